// File: doc/BRIEF.md
# Disk Head Step and Restore Sequencer

This block positions the read/write heads of one hard-disk drive port. It takes a seek or restore command and issues step pulses to the drive. Each pulse moves the head by one cylinder. An active-low direction line selects the way the head moves. The block keeps a copy of the cylinder the head is on and raises busy for as long as a command is running.

Seeks and rate-paced restores space their pulses by a programmable rate value. The auto-restore variant does not use the timer: after each pulse it waits for the drive to report seek complete.

A restore steps outward until the drive reports track zero, up to a fixed pulse limit. If track zero never appears, an error flag is raised. Commands are refused with an aborted-command flag when the drive is not ready or reports a write fault. The block also drives the reduced-write-current line while a write or format command is active and the head is on or past a programmable cylinder boundary.

Top module: `dss_seq`

## Requirements
- R1: After reset, step_n, dir_n and rwc_n are high, busy, trk0_err and abort_err are low, and cur_cyl is 0.
- R2: A seek targets the 10-bit cylinder formed by cyl_hi as bits 9..8 and cyl_lo as bits 7..0.
- R3: A seek issues exactly one step pulse per cylinder between cur_cyl and the target, and cur_cyl moves by one at the end of each pulse. A seek to the current cylinder issues no pulse and holds busy for exactly one cycle.
- R4: dir_n is high (outward, toward cylinder 0) when the target is below cur_cyl and low (inward) otherwise. dir_n is set at least one clock before step_n falls and does not change while step_n is low.
- R5: Each step pulse holds step_n low for STEP_W clocks (2 by default). With rate-based pacing, step_n stays high for step_rate*RATE_UNIT+3 clocks (RATE_UNIT is 4 by default) between consecutive pulses of one command.
- R6: A restore (cmd_op 1) samples trk0_n before every pulse. It steps outward until trk0_n is low, then ends with cur_cyl at 0 and trk0_err low.
- R7: A restore that has issued MAX_RESTORE pulses (1023) with trk0_n still high sets trk0_err, drops busy, issues no further pulse and leaves cur_cyl unchanged.
- R8: An auto-restore (cmd_op 2) behaves as R6, but after each pulse it waits for seek_cmp_n low instead of the rate timer. It then needs two more clocks before the next pulse falls.
- R9: A seek (cmd_op 0) ends without looking at seek_cmp_n, so busy drops even with seek_cmp_n held high.
- R10: A command offered while idle is refused when drv_ready is low, wr_fault is high or cmd_op is 3. A refused command sets abort_err, leaves busy low and issues no pulse. Any accepted command clears both abort_err and trk0_err.
- R11: One clock after the inputs, rwc_n is low exactly when wr_cmd_act is high and cur_cyl is greater than or equal to four times precomp; otherwise it is high.
- R12: busy rises on the clock that accepts a command and falls when the command ends. A cmd_valid arriving while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 2 | 0 seek, 1 restore, 2 auto-restore, 3 refused |
| cyl_hi | input | 2 | Target cylinder bits 9..8 |
| cyl_lo | input | 8 | Target cylinder bits 7..0 |
| step_rate | input | 4 | Rate code; gap unit count between pulses |
| precomp | input | 8 | Reduced-write-current boundary divided by four |
| wr_cmd_act | input | 1 | A write or format command is in progress |
| drv_ready | input | 1 | Drive ready |
| wr_fault | input | 1 | Drive write fault |
| trk0_n | input | 1 | Track zero, active low |
| seek_cmp_n | input | 1 | Seek complete, active low |
| step_n | output | 1 | Step pulse, active low |
| dir_n | output | 1 | Direction, high outward, low inward |
| rwc_n | output | 1 | Reduced write current, active low |
| busy | output | 1 | Command in progress |
| trk0_err | output | 1 | Restore found no track zero |
| abort_err | output | 1 | Last offered command was refused |
| cur_cyl | output | 10 | Current cylinder |

## Verification
The assertions assume that trk0_n and seek_cmp_n are already synchronous to clk and that the rate, cylinder and precomp inputs hold steady while busy is high. The stimulus changes every input only on falling clock edges. A drive model in the bench moves a head count on each step edge and derives trk0_n from that count, with a switch that holds trk0_n high. Seek complete returns a fixed number of clocks after each step, or is held inactive on purpose for the seek-overlap case.

// File: rtl/dss_pkg.sv
// Shared types for the step sequencer.
// Assumes: the command code is two bits wide and its values are fixed by the host side.
package dss_pkg;
    typedef enum logic [1:0] {
        OP_SEEK    = 2'd0,
        OP_RESTORE = 2'd1,
        OP_AUTO    = 2'd2,
        OP_RSVD    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SETUP,
        ST_PULSE,
        ST_GAP,
        ST_WAIT_SC
    } st_e;
endpackage

// File: rtl/dss_timer.sv
// Down-counter used for pulse width and inter-pulse gap.
// Assumes: load has priority; the counter parks at zero.
module dss_timer #(
    parameter int TMR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] cnt;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dss_pos.sv
// Holds the current and target cylinder and compares them.
// Assumes: the control unit never steps past cylinder 0 or the top cylinder during a seek.
module dss_pos #(
    parameter int CYL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_load,
    input  logic [CYL_W-1:0] tgt_val,
    input  logic             step_en,
    input  logic             step_out,
    input  logic             clr,
    output logic [CYL_W-1:0] cur,
    output logic             at_tgt,
    output logic             tgt_below
);
    logic [CYL_W-1:0] tgt;

    // Capture the seek target when a seek is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        tgt <= '0;
        else if (tgt_load) tgt <= tgt_val;
    end

    // Move the current cylinder one step or zero it after a restore.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur <= '0;
        else if (clr)     cur <= '0;
        else if (step_en) cur <= step_out ? cur - 1'b1 : cur + 1'b1;
    end

    assign at_tgt    = (cur == tgt);
    assign tgt_below = (tgt < cur);
endmodule

// File: rtl/dss_rwc.sv
// Reduced-write-current decision: cylinder against four times the boundary register.
// Assumes: output is registered, one clock behind its inputs.
module dss_rwc #(
    parameter int CYL_W = 10,
    parameter int PC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_act,
    input  logic [CYL_W-1:0] cur,
    input  logic [PC_W-1:0]  precomp,
    output logic             rwc_n
);
    localparam int CMP_W = (CYL_W > PC_W + 2) ? CYL_W : PC_W + 2;

    logic [CMP_W-1:0] cyl_ext;
    logic [CMP_W-1:0] bnd_ext;
    logic             hit;

    // Widen both operands and form the boundary as precomp times four.
    always_comb begin
        cyl_ext = CMP_W'(cur);
        bnd_ext = CMP_W'({precomp, 2'b00});
        hit     = wr_act && (cyl_ext >= bnd_ext);
    end

    // Register the active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) rwc_n <= 1'b1;
        else        rwc_n <= !hit;
    end
endmodule

// File: rtl/dss_ctrl.sv
// Command sequencer: accepts or refuses commands, orders direction setup,
// step pulses and pacing, and ends seeks and restores.
// Assumes: trk0_n and seek_cmp_n are synchronous to clk.
module dss_ctrl
    import dss_pkg::*;
#(
    parameter int RATE_W      = 4,
    parameter int TMR_W       = 6,
    parameter int RST_W       = 10,
    parameter int STEP_W      = 2,
    parameter int RATE_UNIT   = 4,
    parameter int MAX_RESTORE = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [RATE_W-1:0] step_rate,
    input  logic              drv_ready,
    input  logic              wr_fault,
    input  logic              trk0_n,
    input  logic              seek_cmp_n,
    input  logic              at_tgt,
    input  logic              tgt_below,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              tgt_load,
    output logic              pos_step,
    output logic              pos_out,
    output logic              pos_clr,
    output logic              step_n,
    output logic              dir_n,
    output logic              busy,
    output logic              trk0_err,
    output logic              abort_err
);
    st_e              st;
    op_e              op_q;
    op_e              op_in;
    logic [RST_W-1:0] rcnt;
    logic             accept;
    logic             pulse_end;
    logic             at_zero;

    // Decode the offered command and the end-of-pulse point.
    always_comb begin
        op_in     = op_e'(cmd_op);
        accept    = drv_ready && !wr_fault && (op_in != OP_RSVD);
        pulse_end = (st == ST_PULSE) && tmr_zero;
        at_zero   = !trk0_n;
    end

    // Drive the position unit and the interval timer.
    always_comb begin
        tgt_load = (st == ST_IDLE) && cmd_valid && accept && (op_in == OP_SEEK);
        pos_step = pulse_end && (op_q == OP_SEEK);
        pos_out  = dir_n;
        pos_clr  = (st == ST_DECIDE) && (op_q != OP_SEEK) && at_zero;
        tmr_load = (st == ST_SETUP) || (pulse_end && (op_q != OP_AUTO));
        if (st == ST_SETUP) tmr_val = TMR_W'(STEP_W - 1);
        else                tmr_val = TMR_W'(step_rate) * TMR_W'(RATE_UNIT);
    end

    // Main sequencing state machine and its registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            op_q      <= OP_SEEK;
            rcnt      <= '0;
            step_n    <= 1'b1;
            dir_n     <= 1'b1;
            busy      <= 1'b0;
            trk0_err  <= 1'b0;
            abort_err <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        trk0_err <= 1'b0;
                        if (accept) begin
                            abort_err <= 1'b0;
                            busy      <= 1'b1;
                            op_q      <= op_in;
                            rcnt      <= '0;
                            st        <= ST_DECIDE;
                        end else begin
                            abort_err <= 1'b1;
                        end
                    end
                end
                ST_DECIDE: begin
                    if (op_q == OP_SEEK) begin
                        if (at_tgt) begin
                            busy <= 1'b0;
                            st   <= ST_IDLE;
                        end else begin
                            dir_n <= tgt_below;
                            st    <= ST_SETUP;
                        end
                    end else if (at_zero) begin
                        busy <= 1'b0;
                        st   <= ST_IDLE;
                    end else if (rcnt == RST_W'(MAX_RESTORE)) begin
                        trk0_err <= 1'b1;
                        busy     <= 1'b0;
                        st       <= ST_IDLE;
                    end else begin
                        dir_n <= 1'b1;
                        st    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    step_n <= 1'b0;
                    st     <= ST_PULSE;
                end
                ST_PULSE: begin
                    if (tmr_zero) begin
                        step_n <= 1'b1;
                        if (op_q != OP_SEEK) rcnt <= rcnt + 1'b1;
                        st <= (op_q == OP_AUTO) ? ST_WAIT_SC : ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tmr_zero) st <= ST_DECIDE;
                end
                ST_WAIT_SC: begin
                    if (!seek_cmp_n) st <= ST_DECIDE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dss_seq.sv
// Top level of the head step and restore sequencer.
// Assumes: the cylinder, rate and precomp inputs are stable while busy.
module dss_seq #(
    parameter int CYL_W       = 10,
    parameter int PC_W        = 8,
    parameter int RATE_W      = 4,
    parameter int RATE_UNIT   = 4,
    parameter int STEP_W      = 2,
    parameter int MAX_RESTORE = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CYL_W-9:0]  cyl_hi,
    input  logic [7:0]        cyl_lo,
    input  logic [RATE_W-1:0] step_rate,
    input  logic [PC_W-1:0]   precomp,
    input  logic              wr_cmd_act,
    input  logic              drv_ready,
    input  logic              wr_fault,
    input  logic              trk0_n,
    input  logic              seek_cmp_n,
    output logic              step_n,
    output logic              dir_n,
    output logic              rwc_n,
    output logic              busy,
    output logic              trk0_err,
    output logic              abort_err,
    output logic [CYL_W-1:0]  cur_cyl
);
    localparam int GAP_MAX = ((1 << RATE_W) - 1) * RATE_UNIT;
    localparam int TMR_MAX = (GAP_MAX > STEP_W) ? GAP_MAX : STEP_W;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int RST_W   = $clog2(MAX_RESTORE + 1);

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             tgt_load;
    logic             pos_step;
    logic             pos_out;
    logic             pos_clr;
    logic             at_tgt;
    logic             tgt_below;
    logic [CYL_W-1:0] tgt_val;

    assign tgt_val = {cyl_hi, cyl_lo};

    dss_ctrl #(
        .RATE_W(RATE_W), .TMR_W(TMR_W), .RST_W(RST_W),
        .STEP_W(STEP_W), .RATE_UNIT(RATE_UNIT), .MAX_RESTORE(MAX_RESTORE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .step_rate(step_rate), .drv_ready(drv_ready), .wr_fault(wr_fault),
        .trk0_n(trk0_n), .seek_cmp_n(seek_cmp_n), .at_tgt(at_tgt),
        .tgt_below(tgt_below), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .tgt_load(tgt_load), .pos_step(pos_step),
        .pos_out(pos_out), .pos_clr(pos_clr), .step_n(step_n), .dir_n(dir_n),
        .busy(busy), .trk0_err(trk0_err), .abort_err(abort_err)
    );

    dss_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    dss_pos #(.CYL_W(CYL_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .tgt_load(tgt_load), .tgt_val(tgt_val),
        .step_en(pos_step), .step_out(pos_out), .clr(pos_clr), .cur(cur_cyl),
        .at_tgt(at_tgt), .tgt_below(tgt_below)
    );

    dss_rwc #(.CYL_W(CYL_W), .PC_W(PC_W)) u_rwc (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_cmd_act), .cur(cur_cyl),
        .precomp(precomp), .rwc_n(rwc_n)
    );
endmodule

// File: rtl/dss_seq_chk.sv
// Property checker for the step sequencer, attached by bind.
// Assumes: only top-level ports are observed.
module dss_seq_chk #(
    parameter int CYL_W  = 10,
    parameter int STEP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic             drv_ready,
    input logic             wr_fault,
    input logic             wr_cmd_act,
    input logic             step_n,
    input logic             dir_n,
    input logic             rwc_n,
    input logic             trk0_err,
    input logic             abort_err,
    input logic [CYL_W-1:0] cur_cyl
);
    logic [7:0] low_len;

    // Count how long step_n has been low.
    always_ff @(posedge clk) begin
        if (!rst_n)       low_len <= '0;
        else if (!step_n) low_len <= low_len + 1'b1;
        else              low_len <= '0;
    end

    // R4
    dir_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_n) |-> $stable(dir_n));
    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_n && $past(!step_n)) |-> $stable(dir_n));
    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_n) |-> (low_len == 8'(STEP_W)));
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> step_n);
    // R11
    rwc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmd_act |=> rwc_n);
    // R10
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (!drv_ready || wr_fault)) |=> (abort_err && !busy));
    // R7
    trk0_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk0_err |-> !busy);
    // R3
    cyl_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_cyl) |-> ($rose(step_n) || cur_cyl == '0));
endmodule

bind dss_seq dss_seq_chk #(.CYL_W(CYL_W), .STEP_W(STEP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .drv_ready(drv_ready), .wr_fault(wr_fault), .wr_cmd_act(wr_cmd_act),
    .step_n(step_n), .dir_n(dir_n), .rwc_n(rwc_n), .trk0_err(trk0_err),
    .abort_err(abort_err), .cur_cyl(cur_cyl)
);

// File: tb/tb_dss_seq.sv
// Bench for dss_seq: behavioural per-cycle model plus directed checks.
module tb_dss_seq;
    localparam int SC_DLY = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [1:0] cyl_hi = 2'd0;
    logic [7:0] cyl_lo = 8'd0;
    logic [3:0] step_rate = 4'd0;
    logic [7:0] precomp = 8'd0;
    logic       wr_cmd_act = 1'b0;
    logic       drv_ready = 1'b1;
    logic       wr_fault = 1'b0;
    logic       trk0_n;
    logic       seek_cmp_n;
    logic       step_n, dir_n, rwc_n, busy, trk0_err, abort_err;
    logic [9:0] cur_cyl;

    int  head = 0;
    bit  trk0_stuck = 1'b0;
    bit  sc_hold = 1'b0;
    bit  sc_raw = 1'b0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    assign trk0_n     = (head == 0 && !trk0_stuck) ? 1'b0 : 1'b1;
    assign seek_cmp_n = sc_hold ? 1'b1 : sc_raw;

    always #5 clk = ~clk;

    dss_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cyl_hi(cyl_hi), .cyl_lo(cyl_lo), .step_rate(step_rate), .precomp(precomp),
        .wr_cmd_act(wr_cmd_act), .drv_ready(drv_ready), .wr_fault(wr_fault),
        .trk0_n(trk0_n), .seek_cmp_n(seek_cmp_n), .step_n(step_n), .dir_n(dir_n),
        .rwc_n(rwc_n), .busy(busy), .trk0_err(trk0_err), .abort_err(abort_err),
        .cur_cyl(cur_cyl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive model: head follows step edges, seek complete returns later
    always @(posedge step_n) begin
        if (dir_n) begin if (head > 0) head = head - 1; end
        else head = head + 1;
    end
    always @(posedge step_n) begin
        sc_raw = 1'b1;
        repeat (SC_DLY) @(negedge clk);
        sc_raw = 1'b0;
    end

    // behavioural reference, advanced at each rising edge
    int m_st, m_left, m_cur, m_tgt, m_op, m_cnt;
    bit m_busy, m_step, m_dir, m_rwc, m_tz, m_ab;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_cur = 0; m_tgt = 0; m_op = 0; m_cnt = 0;
            m_busy = 0; m_step = 1; m_dir = 1; m_rwc = 1; m_tz = 0; m_ab = 0;
        end else begin
            m_rwc = !(wr_cmd_act && (m_cur >= 4 * int'(precomp)));
            if (m_st == 0) begin
                if (cmd_valid) begin
                    m_tz = 0;
                    if (!drv_ready || wr_fault || cmd_op == 2'd3) m_ab = 1;
                    else begin
                        m_ab = 0; m_busy = 1; m_op = int'(cmd_op); m_cnt = 0; m_st = 1;
                        if (cmd_op == 2'd0) m_tgt = int'(cyl_hi) * 256 + int'(cyl_lo);
                    end
                end
            end else if (m_st == 1) begin
                if (m_op == 0) begin
                    if (m_cur == m_tgt) begin m_busy = 0; m_st = 0; end
                    else begin m_dir = (m_tgt < m_cur); m_st = 2; end
                end else if (!trk0_n) begin m_cur = 0; m_busy = 0; m_st = 0; end
                else if (m_cnt == 1023) begin m_tz = 1; m_busy = 0; m_st = 0; end
                else begin m_dir = 1; m_st = 2; end
            end else if (m_st == 2) begin
                m_step = 0; m_left = 2; m_st = 3;
            end else if (m_st == 3) begin
                m_left--;
                if (m_left == 0) begin
                    m_step = 1;
                    if (m_op == 0) m_cur = m_dir ? m_cur - 1 : m_cur + 1;
                    else m_cnt++;
                    if (m_op == 2) m_st = 5;
                    else begin m_left = int'(step_rate) * 4 + 1; m_st = 4; end
                end
            end else if (m_st == 4) begin
                m_left--;
                if (m_left == 0) m_st = 1;
            end else begin
                if (!seek_cmp_n) m_st = 1;
            end
        end
    end

    // per-cycle comparison and pulse measurement
    bit prev_step = 1'b1;
    int n_steps, n_out, n_in, lo_cnt, hi_cnt, lo_min, lo_max, gap_min, gap_max, busy_cyc;
    bit seen_rise;
    task automatic clr_mon();
        n_steps = 0; n_out = 0; n_in = 0; lo_cnt = 0; hi_cnt = 0; busy_cyc = 0;
        lo_min = 999; lo_max = 0; gap_min = 999; gap_max = 0; seen_rise = 0;
    endtask
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R12 busy", busy, m_busy);
            chk(step_n == m_step, "R5 step_n", step_n, m_step);
            chk(dir_n == m_dir, "R4 dir_n", dir_n, m_dir);
            chk(rwc_n == m_rwc, "R11 rwc_n", rwc_n, m_rwc);
            chk(trk0_err == m_tz, "R7 trk0_err", trk0_err, m_tz);
            chk(abort_err == m_ab, "R10 abort_err", abort_err, m_ab);
            chk(int'(cur_cyl) == m_cur, "R3 cur_cyl", cur_cyl, m_cur);
        end
        if (busy) busy_cyc++;
        if (prev_step && !step_n) begin
            n_steps++;
            if (dir_n) n_out++; else n_in++;
            if (seen_rise) begin
                if (hi_cnt < gap_min) gap_min = hi_cnt;
                if (hi_cnt > gap_max) gap_max = hi_cnt;
            end
            lo_cnt = 0;
        end
        if (!prev_step && step_n) begin
            seen_rise = 1;
            if (lo_cnt < lo_min) lo_min = lo_cnt;
            if (lo_cnt > lo_max) lo_max = lo_cnt;
            hi_cnt = 0;
        end
        if (step_n) hi_cnt++; else lo_cnt++;
        prev_step = step_n;
    end

    task automatic issue(input logic [1:0] op, input logic [1:0] hi, input logic [7:0] lo);
        @(negedge clk);
        cmd_op = op; cyl_hi = hi; cyl_lo = lo; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [1:0] hi, input logic [7:0] lo);
        clr_mon();
        issue(op, hi, lo);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        clr_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(step_n && dir_n && rwc_n, "R1 lines", {step_n, dir_n, rwc_n}, 7);
        chk(!busy && !trk0_err && !abort_err, "R1 flags", {busy, trk0_err, abort_err}, 0);
        chk(cur_cyl == 10'd0, "R1 cyl", cur_cyl, 0);

        // R2 split target, inward
        step_rate = 4'd1;
        run_cmd(2'd0, 2'b01, 8'h05);
        chk(cur_cyl == 10'd261, "R2 target", cur_cyl, 261);
        chk(n_steps == 261, "R3 pulse count", n_steps, 261);
        chk(n_in == 261, "R4 inward", n_in, 261);
        chk(gap_min == 7 && gap_max == 7, "R5 gap rate1", gap_max, 7);

        // R4 R5 outward seek, rate 2
        step_rate = 4'd2;
        run_cmd(2'd0, 2'b00, 8'h10);
        chk(n_out == 245 && n_steps == 245, "R4 outward", n_out, 245);
        chk(lo_min == 2 && lo_max == 2, "R5 width", lo_max, 2);
        chk(gap_min == 11 && gap_max == 11, "R5 gap rate2", gap_max, 11);

        // R3 zero-distance seek
        run_cmd(2'd0, 2'b00, 8'h10);
        chk(n_steps == 0, "R3 no pulse", n_steps, 0);
        chk(busy_cyc == 1, "R3 busy one cycle", busy_cyc, 1);

        // R12 command while busy ignored
        step_rate = 4'd0;
        clr_mon();
        issue(2'd0, 2'b00, 8'd40);
        repeat (3) @(negedge clk);
        issue(2'd0, 2'b00, 8'd100);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cur_cyl == 10'd40, "R12 ignored", cur_cyl, 40);
        chk(n_steps == 24, "R12 pulses", n_steps, 24);

        // R11 reduced write current at cylinder 40
        wr_cmd_act = 1'b1; precomp = 8'd10;
        repeat (2) @(negedge clk);
        chk(rwc_n == 1'b0, "R11 equal", rwc_n, 0);
        precomp = 8'd11;
        repeat (2) @(negedge clk);
        chk(rwc_n == 1'b1, "R11 above", rwc_n, 1);
        precomp = 8'd0;
        repeat (2) @(negedge clk);
        chk(rwc_n == 1'b0, "R11 zero", rwc_n, 0);
        wr_cmd_act = 1'b0;
        repeat (2) @(negedge clk);
        chk(rwc_n == 1'b1, "R11 no write", rwc_n, 1);

        // R10 refusals
        clr_mon();
        drv_ready = 1'b0;
        issue(2'd1, 2'b00, 8'd0);
        chk(abort_err && !busy, "R10 not ready", {abort_err, busy}, 2);
        drv_ready = 1'b1; wr_fault = 1'b1;
        issue(2'd0, 2'b00, 8'd3);
        chk(abort_err && !busy, "R10 fault", {abort_err, busy}, 2);
        wr_fault = 1'b0;
        issue(2'd3, 2'b00, 8'd3);
        chk(abort_err && !busy, "R10 op3", {abort_err, busy}, 2);
        repeat (5) @(negedge clk);
        chk(n_steps == 0 && cur_cyl == 10'd40, "R10 no motion", n_steps, 0);

        // R6 rate-paced restore from 40 (also clears abort_err)
        run_cmd(2'd1, 2'b00, 8'd0);
        chk(!abort_err, "R10 cleared", abort_err, 0);
        chk(n_out == 40 && n_steps == 40, "R6 pulses", n_steps, 40);
        chk(cur_cyl == 10'd0 && !trk0_err, "R6 end", cur_cyl, 0);

        // R8 auto-restore from 5
        run_cmd(2'd0, 2'b00, 8'd5);
        run_cmd(2'd2, 2'b00, 8'd0);
        chk(n_steps == 5 && cur_cyl == 10'd0, "R8 pulses", n_steps, 5);
        chk(gap_min == SC_DLY + 2 && gap_max == SC_DLY + 2, "R8 pacing", gap_max, SC_DLY + 2);

        // R9 seek ends without seek complete
        sc_hold = 1'b1;
        run_cmd(2'd0, 2'b00, 8'd7);
        chk(!busy && cur_cyl == 10'd7, "R9 no wait", cur_cyl, 7);
        sc_hold = 1'b0;

        // R7 restore with track zero never seen
        trk0_stuck = 1'b1;
        run_cmd(2'd1, 2'b00, 8'd0);
        chk(n_steps == 1023, "R7 cap", n_steps, 1023);
        chk(trk0_err && !busy && cur_cyl == 10'd7, "R7 flag", {trk0_err, busy}, 2);
        repeat (20) @(negedge clk);
        chk(n_steps == 1023, "R7 stopped", n_steps, 1023);
        trk0_stuck = 1'b0;
        run_cmd(2'd0, 2'b00, 8'd7);
        chk(!trk0_err, "R10 clears trk0_err", trk0_err, 0);

        done = 1'b1;
        finish_run();
    end
endmodule